// File: doc/BRIEF.md
# Timer Run and External Interrupt Flag Register

This block is one byte-wide control register for a small 8-bit microcontroller. It holds the run enables for two timers and the request flags for two timer overflows and two external interrupt pins. Hardware sets the request flags. Software clears them, and so does the interrupt vector acknowledge. Software reaches the register in two ways: a byte port that reads and writes all eight bits, and a single-bit port that changes one bit and leaves the others as they are.

Each external pin first goes through a synchronizer. A per-bit type select then picks one of two modes. In edge mode the flag latches on one active transition. In level mode the flag follows the pin's active level. A separate polarity input for each pin selects whether low/falling or high/rising counts as active. The timers, interrupt priority and the CPU are outside this block. There is no streaming data path, so every pin is a plain control or status signal with no back-pressure.

Top module: `tmr_xint_ctl`

## Requirements
- R1: After reset every register bit is 0, so a read at the base address returns 0x00 and all run and request outputs are low.
- R2: A one-cycle timer overflow pulse sets that timer's request flag on the next clock edge, and the flag stays set until something clears it.
- R3: A timer flag, or an edge-mode external flag, is cleared by its acknowledge strobe or by a software write of 0. When a hardware set and a clear happen in the same cycle, the set wins.
- R4: The timer run outputs equal register bits 4 (timer 0) and 6 (timer 1). They change only through a byte or bit write.
- R5: A byte write at the base address (default 0x88) loads all eight bits, and a byte write at any other address changes nothing. The read port returns the register at the base address and 0x00 elsewhere. Bit layout, from 7 down to 0: timer-1 flag, timer-1 run, timer-0 flag, timer-0 run, ext-1 flag, ext-1 type, ext-0 flag, ext-0 type.
- R6: A bit write at address base+n, for n from 0 to 7, sets bit n to the supplied value and leaves the other bits unchanged. A bit write outside base..base+7 is ignored.
- R7: With type bit 1 (edge mode), one active transition of the synchronized pin sets the flag once. The flag becomes visible three clocks after the pin change is first sampled. A pin held at its active level does not set the flag again after software clears it.
- R8: With type bit 0 (level mode), the flag reads as the synchronized active level, which appears two clocks after the pin changes. Neither the acknowledge strobe nor a software clear has any lasting effect while the level stays active.
- R9: A polarity input of 0 makes low or falling active, and 1 makes high or rising active. Changing the polarity alone creates no edge event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte port address, used for both read and write |
| reg_wr_en | input | 1 | Byte write strobe |
| reg_wdata | input | 8 | Byte write data |
| reg_rdata | output | 8 | Register contents when reg_addr matches, otherwise 0 |
| bit_wr_en | input | 1 | Single-bit write strobe |
| bit_addr | input | 8 | Bit address (base+index) |
| bit_wval | input | 1 | Value written to the addressed bit |
| tmr_ovf | input | 2 | Timer overflow pulses, one bit per timer |
| tmr_ack | input | 2 | Timer vector acknowledge strobes |
| ext_pin | input | 2 | Asynchronous external interrupt pins |
| ext_pol | input | 2 | Active polarity per pin (0 low/falling, 1 high/rising) |
| ext_ack | input | 2 | External vector acknowledge strobes |
| tmr_run | output | 2 | Timer run enables |
| tmr_irq | output | 2 | Timer overflow request flags |
| ext_irq | output | 2 | External interrupt request flags |
| ext_edge_mode | output | 2 | Type select per pin (1 edge, 0 level) |

## Verification
A table of byte writes mixes the type bits with the flag bits. Its read-backs show that edge-mode flags keep what software wrote, while level-mode flags show the inactive pin level instead. Directed sequences then drive falling and rising edges, held active levels and polarity flips. These sequences separate latching from level following, and a real transition from a polarity change. Same-cycle set and clear pulses check which of the two wins. Bit writes inside and outside the eight-address window check that a bit write reaches only its addressed bit.

// File: rtl/tmr_xint_pkg.sv
package tmr_xint_pkg;

  localparam int NUM_TMR = 2;
  localparam int NUM_EXT = 2;
  localparam int REG_W   = 8;

  typedef enum logic {
    SENSE_LEVEL = 1'b0,
    SENSE_EDGE  = 1'b1
  } sense_e;

  // Bit positions within the register; the read layout depends on them.
  function automatic int tmr_flag_pos(input int idx);
    return 5 + 2 * idx;
  endfunction

  function automatic int tmr_run_pos(input int idx);
    return 4 + 2 * idx;
  endfunction

  function automatic int ext_flag_pos(input int idx);
    return 1 + 2 * idx;
  endfunction

  function automatic int ext_type_pos(input int idx);
    return 2 * idx;
  endfunction

endpackage

// File: rtl/xint_sense.sv
// Synchronizes one external pin and derives its active level and active edge.
module xint_sense #(
  parameter int   SYNC_STAGES = 2,
  parameter logic PIN_IDLE    = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic pol,
  output logic active,
  output logic edge_hit
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {SYNC_STAGES{PIN_IDLE}};
      prev_q <= PIN_IDLE;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pin_s    = sync_q[SYNC_STAGES-1];
  assign active   = (pin_s == pol);
  assign edge_hit = active && (pin_s != prev_q);

endmodule

// File: rtl/flag_bit.sv
// One request flag. Priority: hardware set, then software write, then clear.
module flag_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic hw_set,
  input  logic sw_we,
  input  logic sw_val,
  input  logic ack_clr,
  input  logic force_clr,
  output logic q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= 1'b0;
    end else if (hw_set) begin
      q <= 1'b1;
    end else if (sw_we) begin
      q <= sw_val;
    end else if (ack_clr || force_clr) begin
      q <= 1'b0;
    end
  end

endmodule

// File: rtl/tmr_xint_ctl.sv
module tmr_xint_ctl
  import tmr_xint_pkg::*;
#(
  parameter int                ADDR_W      = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR   = 8'h88,
  parameter int                SYNC_STAGES = 2,
  parameter logic              PIN_IDLE    = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr_en,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic              bit_wr_en,
  input  logic [ADDR_W-1:0] bit_addr,
  input  logic              bit_wval,
  input  logic [1:0]        tmr_ovf,
  input  logic [1:0]        tmr_ack,
  input  logic [1:0]        ext_pin,
  input  logic [1:0]        ext_pol,
  input  logic [1:0]        ext_ack,
  output logic [1:0]        tmr_run,
  output logic [1:0]        tmr_irq,
  output logic [1:0]        ext_irq,
  output logic [1:0]        ext_edge_mode
);

  localparam int SEL_W = $clog2(REG_W);

  logic             byte_hit;
  logic             bit_hit;
  logic [SEL_W-1:0] bit_sel;
  logic [REG_W-1:0] wr_mask;
  logic [REG_W-1:0] wr_val;
  logic [REG_W-1:0] reg_view;

  // Write decode shared by the byte and bit ports; a bit write overrides its bit.
  assign byte_hit = reg_wr_en && (reg_addr == BASE_ADDR);
  assign bit_hit  = bit_wr_en && (bit_addr[ADDR_W-1:SEL_W] == BASE_ADDR[ADDR_W-1:SEL_W]);
  assign bit_sel  = bit_addr[SEL_W-1:0];

  always_comb begin
    for (int b = 0; b < REG_W; b++) begin
      if (bit_hit && (bit_sel == SEL_W'(b))) begin
        wr_mask[b] = 1'b1;
        wr_val[b]  = bit_wval;
      end else begin
        wr_mask[b] = byte_hit;
        wr_val[b]  = reg_wdata[b];
      end
    end
  end

  // Timer slices
  for (genvar t = 0; t < NUM_TMR; t++) begin : g_tmr
    localparam int FP = tmr_flag_pos(t);
    localparam int RP = tmr_run_pos(t);
    logic run_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          run_q <= 1'b0;
      else if (wr_mask[RP]) run_q <= wr_val[RP];
    end

    flag_bit u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (tmr_ovf[t]),
      .sw_we    (wr_mask[FP]),
      .sw_val   (wr_val[FP]),
      .ack_clr  (tmr_ack[t]),
      .force_clr(1'b0),
      .q        (tmr_irq[t])
    );

    assign tmr_run[t]   = run_q;
    assign reg_view[FP] = tmr_irq[t];
    assign reg_view[RP] = run_q;
  end

  // External interrupt slices
  for (genvar e = 0; e < NUM_EXT; e++) begin : g_ext
    localparam int FP = ext_flag_pos(e);
    localparam int TP = ext_type_pos(e);
    sense_e mode_q;
    logic   is_edge;
    logic   lvl_active;
    logic   edge_hit;
    logic   edge_flag;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           mode_q <= SENSE_LEVEL;
      else if (wr_mask[TP]) mode_q <= sense_e'(wr_val[TP]);
    end

    assign is_edge = (mode_q == SENSE_EDGE);

    xint_sense #(
      .SYNC_STAGES(SYNC_STAGES),
      .PIN_IDLE   (PIN_IDLE)
    ) u_sense (
      .clk     (clk),
      .rst_n   (rst_n),
      .pin     (ext_pin[e]),
      .pol     (ext_pol[e]),
      .active  (lvl_active),
      .edge_hit(edge_hit)
    );

    // In level mode the latch is held empty and the flag shows the live level.
    flag_bit u_flag (
      .clk      (clk),
      .rst_n    (rst_n),
      .hw_set   (edge_hit && is_edge),
      .sw_we    (wr_mask[FP]),
      .sw_val   (wr_val[FP]),
      .ack_clr  (ext_ack[e]),
      .force_clr(!is_edge),
      .q        (edge_flag)
    );

    assign ext_irq[e]       = is_edge ? edge_flag : lvl_active;
    assign ext_edge_mode[e] = is_edge;
    assign reg_view[FP]     = ext_irq[e];
    assign reg_view[TP]     = is_edge;
  end

  assign reg_rdata = (reg_addr == BASE_ADDR) ? reg_view : 8'h00;

endmodule

// File: rtl/tmr_xint_ctl_chk.sv
module tmr_xint_ctl_chk #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h88
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              reg_wr_en,
  input logic [7:0]        reg_rdata,
  input logic              bit_wr_en,
  input logic [ADDR_W-1:0] bit_addr,
  input logic              bit_wval,
  input logic [1:0]        tmr_ovf,
  input logic [1:0]        tmr_ack,
  input logic [1:0]        tmr_run,
  input logic [1:0]        tmr_irq,
  input logic [1:0]        ext_irq,
  input logic [1:0]        ext_edge_mode
);

  for (genvar i = 0; i < 2; i++) begin : g_t
    assert_tmr_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf[i] |=> tmr_irq[i]);

    assert_tmr_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tmr_ack[i] && !tmr_ovf[i] && !reg_wr_en && !bit_wr_en) |=> !tmr_irq[i]);
  end

  assert_run_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!reg_wr_en && !bit_wr_en) |=> $stable(tmr_run));

  assert_readback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == BASE_ADDR) |-> (reg_rdata == {tmr_irq[1], tmr_run[1], tmr_irq[0], tmr_run[0],
                                               ext_irq[1], ext_edge_mode[1], ext_irq[0], ext_edge_mode[0]}));

  assert_other_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr != BASE_ADDR) |-> (reg_rdata == 8'h00));

  assert_bit_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_wr_en && !reg_wr_en && (bit_addr == BASE_ADDR + ADDR_W'(4))) |=> (tmr_run[0] == $past(bit_wval)));

endmodule

bind tmr_xint_ctl tmr_xint_ctl_chk #(
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_addr     (reg_addr),
  .reg_wr_en    (reg_wr_en),
  .reg_rdata    (reg_rdata),
  .bit_wr_en    (bit_wr_en),
  .bit_addr     (bit_addr),
  .bit_wval     (bit_wval),
  .tmr_ovf      (tmr_ovf),
  .tmr_ack      (tmr_ack),
  .tmr_run      (tmr_run),
  .tmr_irq      (tmr_irq),
  .ext_irq      (ext_irq),
  .ext_edge_mode(ext_edge_mode)
);

// File: tb/tb_tmr_xint_ctl.sv
`timescale 1ns/1ps
module tb_tmr_xint_ctl;

  localparam logic [7:0] BASE = 8'h88;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] reg_addr = BASE;
  logic       reg_wr_en = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       bit_wr_en = 1'b0;
  logic [7:0] bit_addr = BASE;
  logic       bit_wval = 1'b0;
  logic [1:0] tmr_ovf = 2'b00;
  logic [1:0] tmr_ack = 2'b00;
  logic [1:0] ext_pin = 2'b11;
  logic [1:0] ext_pol = 2'b00;
  logic [1:0] ext_ack = 2'b00;
  logic [1:0] tmr_run, tmr_irq, ext_irq, ext_edge_mode;

  int n_chk = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  tmr_xint_ctl dut (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr_en(reg_wr_en),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bit_wr_en(bit_wr_en),
    .bit_addr(bit_addr), .bit_wval(bit_wval), .tmr_ovf(tmr_ovf), .tmr_ack(tmr_ack),
    .ext_pin(ext_pin), .ext_pol(ext_pol), .ext_ack(ext_ack), .tmr_run(tmr_run),
    .tmr_irq(tmr_irq), .ext_irq(ext_irq), .ext_edge_mode(ext_edge_mode)
  );

  // {write data, expected read after settling}; pins idle inactive
  localparam logic [15:0] VECS [8] = '{
    16'hA5_A5, 16'h5A_50, 16'hFF_FF, 16'h0F_0F,
    16'h0A_00, 16'hC0_C0, 16'h3C_3C, 16'h00_00
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] a, input logic [7:0] d);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0; reg_addr = BASE;
  endtask

  task automatic wr_bit(input logic [7:0] a, input logic v);
    bit_addr = a; bit_wval = v; bit_wr_en = 1'b1;
    @(negedge clk);
    bit_wr_en = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 read", reg_rdata, 8'h00);
    check("R1 outputs", {tmr_run, tmr_irq, ext_irq, ext_edge_mode}, 8'h00);

    // R5 table of byte writes
    for (int i = 0; i < 8; i++) begin
      wr_byte(BASE, VECS[i][15:8]);
      idle(2);
      check("R5 table", reg_rdata, VECS[i][7:0]);
    end
    wr_byte(8'h89, 8'hFF);
    idle(1);
    check("R5 other addr write", reg_rdata, 8'h00);
    reg_addr = 8'h89;
    idle(1);
    check("R5 other addr read", reg_rdata, 8'h00);
    reg_addr = BASE;

    // R2 timer flag set and hold
    tmr_ovf = 2'b01;
    idle(1);
    tmr_ovf = 2'b00;
    check("R2 set", {6'd0, tmr_irq}, 8'h01);
    idle(2);
    check("R2 hold", {6'd0, tmr_irq}, 8'h01);
    // R3 ack clears
    tmr_ack = 2'b01;
    idle(1);
    tmr_ack = 2'b00;
    check("R3 ack clear", {6'd0, tmr_irq}, 8'h00);
    // R3 set wins over ack
    tmr_ovf = 2'b10; tmr_ack = 2'b10;
    idle(1);
    tmr_ovf = 2'b00; tmr_ack = 2'b00;
    check("R3 set beats ack", {6'd0, tmr_irq}, 8'h02);
    // R3 set wins over software clear
    tmr_ovf = 2'b10;
    bit_addr = BASE + 8'd7; bit_wval = 1'b0; bit_wr_en = 1'b1;
    idle(1);
    tmr_ovf = 2'b00; bit_wr_en = 1'b0;
    check("R3 set beats sw clear", {6'd0, tmr_irq}, 8'h02);
    wr_bit(BASE + 8'd7, 1'b0);
    check("R3 sw clear", {6'd0, tmr_irq}, 8'h00);

    // R6 / R4 bit writes
    wr_bit(BASE + 8'd4, 1'b1);
    check("R4 run0", {6'd0, tmr_run}, 8'h01);
    check("R6 bit set", reg_rdata, 8'h10);
    wr_bit(8'h90, 1'b1);
    check("R6 out of window", reg_rdata, 8'h10);
    wr_bit(BASE + 8'd6, 1'b1);
    check("R6 second bit", reg_rdata, 8'h50);
    wr_bit(BASE + 8'd4, 1'b0);
    check("R4 run clear", {6'd0, tmr_run}, 8'h02);
    idle(2);
    check("R4 hold", {6'd0, tmr_run}, 8'h02);
    wr_byte(BASE, 8'h00);

    // R7 falling edge, polarity 0
    wr_bit(BASE + 8'd0, 1'b1);
    ext_pin[0] = 1'b0;
    idle(4);
    check("R7 edge set", {7'd0, ext_irq[0]}, 8'h01);
    wr_bit(BASE + 8'd1, 1'b0);
    idle(4);
    check("R7 no reset while held", {7'd0, ext_irq[0]}, 8'h00);
    ext_pin[0] = 1'b1;
    idle(4);
    check("R7 release", {7'd0, ext_irq[0]}, 8'h00);
    ext_pin[0] = 1'b0;
    idle(4);
    check("R7 second edge", {7'd0, ext_irq[0]}, 8'h01);
    ext_ack[0] = 1'b1;
    idle(1);
    ext_ack[0] = 1'b0;
    check("R3 edge ack clear", {7'd0, ext_irq[0]}, 8'h00);
    ext_pin[0] = 1'b1;
    idle(4);

    // R9 rising edge on input 1
    wr_bit(BASE + 8'd2, 1'b1);
    ext_pol[1] = 1'b1;
    idle(4);
    check("R9 polarity flip no edge", {7'd0, ext_irq[1]}, 8'h00);
    ext_pin[1] = 1'b0;
    idle(4);
    check("R9 falling ignored", {7'd0, ext_irq[1]}, 8'h00);
    ext_pin[1] = 1'b1;
    idle(4);
    check("R9 rising sets", {7'd0, ext_irq[1]}, 8'h01);

    // R8 level mode on input 0
    wr_byte(BASE, 8'h00);
    idle(1);
    check("R8 inactive", {7'd0, ext_irq[0]}, 8'h00);
    ext_pin[0] = 1'b0;
    idle(4);
    check("R8 active", {7'd0, ext_irq[0]}, 8'h01);
    ext_ack[0] = 1'b1;
    idle(1);
    ext_ack[0] = 1'b0;
    idle(1);
    check("R8 ack no effect", {7'd0, ext_irq[0]}, 8'h01);
    wr_bit(BASE + 8'd1, 1'b0);
    idle(1);
    check("R8 sw clear no effect", {7'd0, ext_irq[0]}, 8'h01);
    ext_pin[0] = 1'b1;
    idle(4);
    check("R8 follows release", {7'd0, ext_irq[0]}, 8'h00);
    ext_pol[0] = 1'b1;
    idle(1);
    check("R9 active high level", {7'd0, ext_irq[0]}, 8'h01);

    summary();
  end

endmodule